// File: doc/BRIEF.md
# Break Length Measurement Unit

This block measures how long a received break lasts on a synchronous serial line, to a resolution of one bit. While a break is in progress every sampled zero is counted. Each run of sixteen zeros counts as one whole break character, and the bits of the character slot currently being filled are recorded in a 16-bit pattern register. Bit 0 of that register holds the first bit written into the slot.

The break ends at the first sampled one. That one is written into the pattern at the next free position. The number of zeros below it gives the fractional part of the break. The block then freezes the whole-character count, the pattern and the total length in bits, and raises a one-cycle break-end pulse.

The unit only listens while its mode enable is high, which corresponds to synchronous operation with the receive-zeros option selected. It only samples a data bit on cycles where the bit-clock enable is high.

Top module: `brk_len_meter`

## Requirements
- R1: During and right after reset, `brk_chars`, `last_pat` and `brk_total` are all zero and `brk_end` is low.
- R2: On a cycle with `bit_en` low, `rx_bit` is ignored: no output changes and no break starts or ends.
- R3: While `meas_en` is low, no bit is taken and `brk_end` stays low, and the outputs hold. A break in progress is abandoned, so a later one does not end it.
- R4: A new break begins at the first sampled zero while no break is in progress. That zero clears `brk_chars` and `last_pat` in the same clock edge.
- R5: Within a break, every run of 16 consecutive sampled zeros adds one to `brk_chars` and restarts the pattern at bit 0.
- R6: A break ends at the first sampled one. `brk_end` is high for exactly the one cycle after the clock edge that samples that one.
- R7: At break end, `last_pat` has a single one at bit position Z mod 16, where Z is the number of zeros in the break; positions below it are zero. For example, 3 zeros give 0x0008 and 16 zeros give 0x0001.
- R8: `brk_total` equals 16 times `brk_chars` plus the number of zeros below the lowest one in `last_pat`. It is updated only at break end and held until the next break end.
- R9: `brk_chars` saturates at 2^CNT_W-1, while the fractional bit position keeps counting.
- R10: A sampled one while no break is in progress has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable; `rx_bit` is valid on this cycle |
| rx_bit | input | 1 | Sampled serial data bit |
| meas_en | input | 1 | Measurement mode enable |
| brk_chars | output | CNT_W | Whole break characters in the last break |
| last_pat | output | PAT_W | Bit pattern of the final break character slot |
| brk_total | output | CNT_W+$clog2(PAT_W+1) | Total break length in bits |
| brk_end | output | 1 | One-cycle pulse when a break ends |

## Verification
The end of one break and the start of the next can fall in the same cycle. This happens when a zero is sampled on the very cycle that `brk_end` is high, because the pulse follows the one that ended the previous break. The bench provokes this by driving a zero right after the terminating one, with `bit_en` held high. It first checks the frozen count, pattern and total while the pulse is high. It then checks that the next edge drops the pulse and clears the count and pattern, while `brk_total` still holds the previous length until the new break ends.

// File: rtl/brk_pkg.sv
package brk_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BREAK = 1'b1
    } brk_state_e;
endpackage

// File: rtl/brk_lz_enc.sv
// Counts zeros from bit 0 up to the lowest set bit; all-zero input yields PAT_W.
module brk_lz_enc #(
    parameter int PAT_W = 16,
    parameter int LZ_W  = $clog2(PAT_W + 1)
) (
    input  logic [PAT_W-1:0] pat,
    output logic [LZ_W-1:0]  lz
);
    always_comb begin
        lz = LZ_W'(PAT_W);
        for (int i = PAT_W - 1; i >= 0; i--) begin
            if (pat[i]) lz = LZ_W'(i);
        end
    end
endmodule

// File: rtl/brk_pat_wr.sv
// Writes one bit into the pattern slot at the given position.
module brk_pat_wr #(
    parameter int PAT_W = 16,
    parameter int POS_W = $clog2(PAT_W)
) (
    input  logic [PAT_W-1:0] pat_i,
    input  logic [POS_W-1:0] pos,
    input  logic             bit_val,
    output logic [PAT_W-1:0] pat_o
);
    for (genvar g = 0; g < PAT_W; g++) begin : g_slot
        assign pat_o[g] = (pos == POS_W'(g)) ? bit_val : pat_i[g];
    end
endmodule

// File: rtl/brk_total_calc.sv
// Combines whole characters and the fractional zero count into bits.
module brk_total_calc #(
    parameter int PAT_W = 16,
    parameter int CNT_W = 8,
    parameter int LZ_W  = $clog2(PAT_W + 1),
    parameter int TOT_W = CNT_W + LZ_W
) (
    input  logic [CNT_W-1:0] chars,
    input  logic [LZ_W-1:0]  lz,
    output logic [TOT_W-1:0] total
);
    assign total = (TOT_W'(chars) * TOT_W'(PAT_W)) + TOT_W'(lz);
endmodule

// File: rtl/brk_len_meter.sv
module brk_len_meter #(
    parameter int CNT_W = 8,
    parameter int PAT_W = 16,
    localparam int POS_W = $clog2(PAT_W),
    localparam int LZ_W  = $clog2(PAT_W + 1),
    localparam int TOT_W = CNT_W + LZ_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic             meas_en,
    output logic [CNT_W-1:0] brk_chars,
    output logic [PAT_W-1:0] last_pat,
    output logic [TOT_W-1:0] brk_total,
    output logic             brk_end
);
    import brk_pkg::*;

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(PAT_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    typedef struct packed {
        brk_state_e       st;
        logic [CNT_W-1:0] chars;
        logic [POS_W-1:0] pos;
        logic [PAT_W-1:0] pat;
        logic [TOT_W-1:0] tot;
        logic             end_p;
    } regs_t;

    regs_t r_d, r_q;

    logic [PAT_W-1:0] pat_wr;
    logic [LZ_W-1:0]  lz_wr;
    logic [TOT_W-1:0] tot_calc;

    brk_pat_wr #(.PAT_W(PAT_W), .POS_W(POS_W)) u_wr (
        .pat_i   (r_q.pat),
        .pos     (r_q.pos),
        .bit_val (rx_bit),
        .pat_o   (pat_wr)
    );

    brk_lz_enc #(.PAT_W(PAT_W), .LZ_W(LZ_W)) u_lz (
        .pat (pat_wr),
        .lz  (lz_wr)
    );

    brk_total_calc #(.PAT_W(PAT_W), .CNT_W(CNT_W), .LZ_W(LZ_W), .TOT_W(TOT_W)) u_tot (
        .chars (r_q.chars),
        .lz    (lz_wr),
        .total (tot_calc)
    );

    always_comb begin
        r_d       = r_q;
        r_d.end_p = 1'b0;
        if (!meas_en) begin
            r_d.st = ST_IDLE;
        end else if (bit_en) begin
            case (r_q.st)
                ST_IDLE: begin
                    if (!rx_bit) begin
                        r_d.st    = ST_BREAK;
                        r_d.chars = '0;
                        r_d.pat   = '0;
                        r_d.pos   = POS_W'(1);
                    end
                end
                ST_BREAK: begin
                    if (rx_bit) begin
                        r_d.st    = ST_IDLE;
                        r_d.pat   = pat_wr;
                        r_d.tot   = tot_calc;
                        r_d.end_p = 1'b1;
                    end else if (r_q.pos == POS_LAST) begin
                        r_d.pos = '0;
                        r_d.pat = '0;
                        if (r_q.chars != CNT_MAX) begin
                            r_d.chars = r_q.chars + 1'b1;
                        end
                    end else begin
                        r_d.pos = r_q.pos + 1'b1;
                        r_d.pat = pat_wr;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, chars: '0, pos: '0, pat: '0, tot: '0, end_p: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign brk_chars = r_q.chars;
    assign last_pat  = r_q.pat;
    assign brk_total = r_q.tot;
    assign brk_end   = r_q.end_p;
endmodule

// File: rtl/brk_len_meter_chk.sv
module brk_len_meter_chk #(
    parameter int CNT_W = 8,
    parameter int PAT_W = 16,
    localparam int TOT_W = CNT_W + $clog2(PAT_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             rx_bit,
    input logic             meas_en,
    input logic [CNT_W-1:0] brk_chars,
    input logic [PAT_W-1:0] last_pat,
    input logic [TOT_W-1:0] brk_total,
    input logic             brk_end
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    a_r6_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |=> !brk_end);

    a_r2_hold_no_en: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(brk_chars) && $stable(last_pat) && $stable(brk_total) && !brk_end));

    a_r3_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> ($stable(brk_chars) && $stable(last_pat) && $stable(brk_total) && !brk_end));

    a_r7_pat_single_one: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |-> ($countones(last_pat) == 1));

    a_r8_total_range: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |-> ((int'(brk_total) >= int'(brk_chars) * PAT_W) &&
                     (int'(brk_total) < (int'(brk_chars) + 1) * PAT_W)));

    a_r8_total_changes_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(brk_total) |-> brk_end);

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_chars == CNT_MAX) |=> ((brk_chars == CNT_MAX) || (brk_chars == '0)));

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((brk_chars == $past(brk_chars)) ||
                  (int'(brk_chars) == int'($past(brk_chars)) + 1) ||
                  (brk_chars == '0)));
endmodule

bind brk_len_meter brk_len_meter_chk #(.CNT_W(CNT_W), .PAT_W(PAT_W)) u_chk (.*);

// File: tb/sim_brk_len_meter.sv
`timescale 1ns/1ps
module sim_brk_len_meter;
    localparam int CNT_W = 4;
    localparam int PAT_W = 16;
    localparam int TOT_W = CNT_W + $clog2(PAT_W + 1);
    localparam int NV    = 12;
    // zeros in break, expected whole characters, expected fractional zeros
    localparam int VEC [NV][3] = '{
        '{1, 0, 1},    '{2, 0, 2},    '{3, 0, 3},    '{15, 0, 15},
        '{16, 1, 0},   '{17, 1, 1},   '{31, 1, 15},  '{32, 2, 0},
        '{47, 2, 15},  '{100, 6, 4},  '{245, 15, 5}, '{275, 15, 3}
    };

    logic clk = 1'b0;
    logic rst_n, bit_en, rx_bit, meas_en;
    logic [CNT_W-1:0] brk_chars;
    logic [PAT_W-1:0] last_pat;
    logic [TOT_W-1:0] brk_total;
    logic             brk_end;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    brk_len_meter #(.CNT_W(CNT_W), .PAT_W(PAT_W)) u0 (
        .clk, .rst_n, .bit_en, .rx_bit, .meas_en,
        .brk_chars, .last_pat, .brk_total, .brk_end
    );

    task automatic drive(input logic b, input logic en);
        rx_bit = b;
        bit_en = en;
        @(negedge clk);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b1);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_end(input string tag, input int ch, input int lz);
        check({tag, " brk_end"}, int'(brk_end), 1);
        check({tag, " chars"}, int'(brk_chars), ch);
        check({tag, " pattern"}, int'(last_pat), 1 << lz);
        check({tag, " total"}, int'(brk_total), ch * PAT_W + lz);
    endtask

    initial begin
        rst_n = 1'b0; meas_en = 1'b1; bit_en = 1'b0; rx_bit = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset chars", int'(brk_chars), 0);
        check("R1 reset pattern", int'(last_pat), 0);
        check("R1 reset total", int'(brk_total), 0);
        check("R1 reset brk_end", int'(brk_end), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: idle ones do nothing
        repeat (3) drive(1'b1, 1'b1);
        check("R10 idle brk_end", int'(brk_end), 0);
        check("R10 idle total", int'(brk_total), 0);

        // table walk: R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            zeros(VEC[k][0]);
            check("R6 no end during break", int'(brk_end), 0);
            drive(1'b1, 1'b1);
            check_end("R7/R8 vector", VEC[k][1], VEC[k][2]);
            drive(1'b1, 1'b1);
            check("R6 pulse one cycle", int'(brk_end), 0);
            check("R10 total held", int'(brk_total), VEC[k][1] * PAT_W + VEC[k][2]);
        end

        // R4: break end and new break start in the same cycle
        zeros(5);
        drive(1'b1, 1'b1);
        check_end("R6 pre-coincidence", 0, 5);
        drive(1'b0, 1'b1);
        check("R4 coincide brk_end", int'(brk_end), 0);
        check("R4 coincide chars clear", int'(brk_chars), 0);
        check("R4 coincide pattern clear", int'(last_pat), 0);
        check("R8 coincide total held", int'(brk_total), 5);
        zeros(19);
        drive(1'b1, 1'b1);
        check_end("R5 after coincidence", 1, 4);

        // R2: ones without bit_en are ignored
        drive(1'b1, 1'b1);
        for (int i = 0; i < 5; i++) begin
            drive(1'b0, 1'b1);
            drive(1'b1, 1'b0);
        end
        check("R2 no end on gated one", int'(brk_end), 0);
        check("R2 total held", int'(brk_total), 20);
        drive(1'b1, 1'b1);
        check_end("R2 gated break", 0, 5);

        // R3: mode disable abandons break
        zeros(3);
        meas_en = 1'b0;
        drive(1'b1, 1'b1);
        check("R3 off brk_end", int'(brk_end), 0);
        check("R3 off total", int'(brk_total), 5);
        check("R3 off pattern", int'(last_pat), 0);
        drive(1'b0, 1'b1);
        check("R3 off zero ignored chars", int'(brk_chars), 0);
        meas_en = 1'b1;
        drive(1'b1, 1'b1);
        check("R3 abandoned no end", int'(brk_end), 0);
        zeros(4);
        drive(1'b1, 1'b1);
        check_end("R3 fresh break", 0, 4);

        // R1: reset mid-break
        zeros(7);
        rst_n = 1'b0;
        drive(1'b0, 1'b1);
        check("R1 mid reset total", int'(brk_total), 0);
        check("R1 mid reset pattern", int'(last_pat), 0);
        rst_n = 1'b1;
        drive(1'b1, 1'b1);
        check("R1 wiped break no end", int'(brk_end), 0);
        zeros(2);
        drive(1'b1, 1'b1);
        check_end("R1 after reset", 0, 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule